// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block drives the memory side of a load-multiple or store-multiple operation. A start pulse captures a base address, a register mask with one bit per architectural register, a load/store select, a direction (up or down), a timing select (adjust before or after each access) and a writeback flag. The sequencer then issues one word access for each set mask bit, with the register index, the word address and a write strobe. Each access waits for a memory-ready handshake before the next one is issued.

The first address is worked out once at start. Accesses are always issued in ascending address order, so the lowest-numbered register in the mask sits at the lowest address in every mode. The four orderings are up-after, up-before, down-after and down-before. A full-descending push is the down-before store, and the matching pop is the up-after load. When the list is done the block pulses done and presents the final base value, flagged as valid for writeback when the writeback flag was set. A base address that is not word aligned ends the operation at once with an error and no access. Moving data into the register file and the memory itself belong to other blocks.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, req_o, done_o, err_o, wb_valid_o and busy_o are all 0.
- R2: The block issues exactly one access for each set bit of mask_i. Register indices are issued in ascending order and addresses rise by 4 bytes per access, so the lowest register is at the lowest address.
- R3: Up-after mode (up_i=1, pre_i=0) puts the first access at the base address.
- R4: Up-before mode (up_i=1, pre_i=1) puts the first access at base+4.
- R5: Down-after mode (up_i=0, pre_i=0) puts the first access at base-4*N+4, where N is the number of set mask bits.
- R6: Down-before mode (up_i=0, pre_i=1) puts the first access at base-4*N.
- R7: At done, wb_base_o is base+4*N (up) or base-4*N (down) and wb_valid_o is 1 when wback_i was set. Without wback_i, wb_valid_o is 0 and wb_base_o equals the base.
- R8: An access with mem_ready_i low is held: req_o stays 1 and addr_o and reg_idx_o do not change until the handshake.
- R9: An all-zero mask gives done_o in the cycle after start, with no access.
- R10: A base whose two low bits are not 00 gives done_o with err_o=1 in the cycle after start, with no access and wb_valid_o=0.
- R11: we_o is 1 on every access of a store (load_i=0) and 0 on every access of a load (load_i=1).
- R12: A start_i pulse while busy_o is 1 is ignored and does not change the transfer in progress.
- R13: done_o is a single-cycle pulse. It comes in the cycle after the last handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| base_i | input | 32 | Base address |
| mask_i | input | 16 | Register selection mask, bit k selects register k |
| load_i | input | 1 | 1 = load (read), 0 = store (write) |
| up_i | input | 1 | 1 = increment, 0 = decrement |
| pre_i | input | 1 | 1 = adjust before access, 0 = after |
| wback_i | input | 1 | Request writeback of the final base |
| mem_ready_i | input | 1 | Memory accepts the current access |
| req_o | output | 1 | Access request valid |
| we_o | output | 1 | Write strobe of the current access |
| reg_idx_o | output | 4 | Register index of the current access |
| addr_o | output | 32 | Word address of the current access |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Transfer finished (one cycle) |
| err_o | output | 1 | Misaligned base, valid with done_o |
| wb_valid_o | output | 1 | Writeback of wb_base_o requested, valid with done_o |
| wb_base_o | output | 32 | Final base value, valid with done_o |

## Verification
The bench builds the block with its default parameters: a 32-bit address, 16 registers and 4-byte words. With these values a full sixteen-register list and address spans that wrap below the base are both reachable. The ready handshake is driven in three patterns (always ready, every other cycle, every third cycle), so that both back-to-back accesses and held accesses are exercised. A push/pop pair starting from a stack pointer value checks that the pointer returns to where it started.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/blk_xfer_plan.sv
// Start address, final base and sanity of a transfer, from the raw request.
module blk_xfer_plan #(
  parameter int ADDR_W     = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [NREG-1:0]   mask_i,
  input  logic              up_i,
  input  logic              pre_i,
  output logic [ADDR_W-1:0] first_addr_o,
  output logic [ADDR_W-1:0] end_base_o,
  output logic              misal_o,
  output logic              empty_o
);
  localparam int CNT_W = $clog2(NREG + 1);
  localparam int AL_W  = $clog2(WORD_BYTES);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] span;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NREG; i++) cnt = cnt + CNT_W'(mask_i[i]);
  end

  assign span    = ADDR_W'(cnt) * STEP;
  assign misal_o = |base_i[AL_W-1:0];
  assign empty_o = (cnt == '0);

  // The lowest register always takes the lowest address, so the down modes start low.
  always_comb begin
    unique case ({up_i, pre_i})
      2'b10:   first_addr_o = base_i;
      2'b11:   first_addr_o = base_i + STEP;
      2'b00:   first_addr_o = base_i - span + STEP;
      default: first_addr_o = base_i - span;
    endcase
    end_base_o = up_i ? base_i + span : base_i - span;
  end
endmodule

// File: rtl/blk_xfer_pick.sv
// Lowest set bit of the remaining list.
module blk_xfer_pick #(
  parameter int NREG  = 16,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic [NREG-1:0]  rem_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [NREG-1:0]  onehot_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (rem_i[i]) idx_o = IDX_W'(i);
    end
  end

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_oh
      if (g == 0) begin : g_first
        assign onehot_o[g] = rem_i[g];
      end else begin : g_rest
        assign onehot_o[g] = rem_i[g] & ~|rem_i[g-1:0];
      end
    end
  endgenerate

  assign any_o = |rem_i;
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [NREG-1:0]   mask_i,
  input  logic              load_i,
  input  logic              up_i,
  input  logic              pre_i,
  input  logic              wback_i,
  input  logic              mem_ready_i,
  output logic              req_o,
  output logic              we_o,
  output logic [IDX_W-1:0]  reg_idx_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              wb_valid_o,
  output logic [ADDR_W-1:0] wb_base_o
);
  localparam int AL_W = $clog2(WORD_BYTES);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  seq_st_e           st_q;
  logic [NREG-1:0]   rem_q;
  logic [ADDR_W-1:0] addr_q, final_q;
  logic              load_q, wback_q, err_q;

  logic [ADDR_W-1:0] pl_first, pl_end;
  logic              pl_misal, pl_empty;
  logic [NREG-1:0]   pk_onehot, rem_next;
  logic              pk_any;

  blk_xfer_plan #(.ADDR_W(ADDR_W), .NREG(NREG), .WORD_BYTES(WORD_BYTES)) i_plan (
    .base_i      (base_i),
    .mask_i      (mask_i),
    .up_i        (up_i),
    .pre_i       (pre_i),
    .first_addr_o(pl_first),
    .end_base_o  (pl_end),
    .misal_o     (pl_misal),
    .empty_o     (pl_empty)
  );

  blk_xfer_pick #(.NREG(NREG), .IDX_W(IDX_W)) i_pick (
    .rem_i   (rem_q),
    .idx_o   (reg_idx_o),
    .onehot_o(pk_onehot),
    .any_o   (pk_any)
  );

  assign rem_next = rem_q & ~pk_onehot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      rem_q   <= '0;
      addr_q  <= '0;
      final_q <= '0;
      load_q  <= 1'b0;
      wback_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          load_q  <= load_i;
          wback_q <= wback_i;
          err_q   <= pl_misal;
          rem_q   <= pl_misal ? '0 : mask_i;
          addr_q  <= pl_first;
          final_q <= (wback_i && !pl_misal) ? pl_end : base_i;
          st_q    <= (pl_misal || pl_empty) ? ST_FIN : ST_RUN;
        end
        ST_RUN: if (mem_ready_i) begin
          rem_q  <= rem_next;
          addr_q <= addr_q + STEP;
          if (rem_next == '0) st_q <= ST_FIN;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_o      = (st_q == ST_RUN) && pk_any;
  assign we_o       = req_o && !load_q;
  assign addr_o     = addr_q;
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = (st_q == ST_FIN);
  assign err_o      = done_o && err_q;
  assign wb_valid_o = done_o && wback_q && !err_q;
  assign wb_base_o  = final_q;

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !mem_ready_i |=> req_o && $stable(addr_o) && $stable(reg_idx_o));

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && mem_ready_i |=> !req_o ||
      (addr_o == $past(addr_o) + STEP && reg_idx_o > $past(reg_idx_o)));

  p_done_pulse_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !req_o);

  p_aligned_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> addr_o[AL_W-1:0] == '0);

  p_start_ignored_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !mem_ready_i && start_i |=> $stable(addr_o) && $stable(we_o));
endmodule

// File: tb/test_blk_xfer_seq.sv
module test_blk_xfer_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base = '0;
  logic [15:0] mask = '0;
  logic        load = 1'b0, up = 1'b0, pre = 1'b0, wback = 1'b0;
  logic        ready = 1'b0;
  logic        req, we, busy, done, err, wb_valid;
  logic [3:0]  reg_idx;
  logic [31:0] addr, wb_base;

  int checks = 0;
  int fails  = 0;
  int rdy_mode = 0;
  int rdy_cnt = 0;
  string rtag = "R2";

  typedef struct {int idx; logic [31:0] a; logic w;} acc_t;
  acc_t exp_q[$];

  logic        hold_v = 1'b0;
  logic [31:0] hold_a;
  logic [3:0]  hold_i;

  always #2 clk = ~clk;

  blk_xfer_seq i_blk_xfer_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base), .mask_i(mask),
    .load_i(load), .up_i(up), .pre_i(pre), .wback_i(wback), .mem_ready_i(ready),
    .req_o(req), .we_o(we), .reg_idx_o(reg_idx), .addr_o(addr), .busy_o(busy),
    .done_o(done), .err_o(err), .wb_valid_o(wb_valid), .wb_base_o(wb_base)
  );

  // Monitor: drives ready and compares each handshake with the scoreboard.
  always @(negedge clk) begin
    logic r;
    rdy_cnt++;
    case (rdy_mode)
      0: r = 1'b1;
      1: r = rdy_cnt[0];
      default: r = (rdy_cnt % 3 == 0);
    endcase
    ready <= r;
    if (hold_v && req) begin
      checks++;
      if (addr !== hold_a || reg_idx !== hold_i) begin
        fails++;
        $display("FAIL R8: held access moved act %h/%0d exp %h/%0d", addr, reg_idx, hold_a, hold_i);
      end
    end
    hold_v = req && !r;
    hold_a = addr;
    hold_i = reg_idx;
    if (req && r) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL %s: unexpected access act idx %0d addr %h exp none", rtag, reg_idx, addr);
      end else begin
        acc_t e;
        e = exp_q.pop_front();
        if (reg_idx !== 4'(e.idx) || addr !== e.a || we !== e.w) begin
          fails++;
          $display("FAIL %s R2 R11: act idx %0d addr %h we %0d exp idx %0d addr %h we %0d",
                   rtag, reg_idx, addr, we, e.idx, e.a, e.w);
        end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: act %h exp %h", tag, act, expv);
    end
  endtask

  task automatic run_xfer(input string tag, input logic [31:0] b, input logic [15:0] m,
                          input logic ld, input logic u, input logic p, input logic wb,
                          input bit poke);
    int n = 0;
    int k = 0;
    int cyc = 0;
    logic [31:0] first, fin;
    logic mis;
    for (int i = 0; i < 16; i++) if (m[i]) n++;
    mis = (b[1:0] != 2'b00);
    if (u && !p)       first = b;
    else if (u && p)   first = b + 32'd4;
    else if (!u && !p) first = b - 32'(4 * n) + 32'd4;
    else               first = b - 32'(4 * n);
    fin = (wb && !mis) ? (u ? b + 32'(4 * n) : b - 32'(4 * n)) : b;
    if (!mis) begin
      for (int i = 0; i < 16; i++) begin
        if (m[i]) begin
          acc_t e;
          e.idx = i; e.a = first + 32'(4 * k); e.w = !ld;
          exp_q.push_back(e);
          k++;
        end
      end
    end
    rtag = tag;
    @(negedge clk);
    base = b; mask = m; load = ld; up = u; pre = p; wback = wb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) begin
      if (poke && cyc == 1) begin
        base = 32'h0000_4000; mask = 16'hFFFF; load = ~ld; up = ~u; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
      if (cyc > 500) begin
        fails++;
        $display("FAIL %s: no done act timeout exp done", tag);
        break;
      end
    end
    start = 1'b0;
    check({tag, " R10 err"}, 32'(err), 32'(mis));
    check({tag, " R7 wb_valid"}, 32'(wb_valid), 32'(wb && !mis));
    check({tag, " R7 wb_base"}, wb_base, fin);
    check({tag, " R2 all accesses"}, 32'(exp_q.size()), 32'd0);
    if (mis || n == 0) check({tag, " R9 R10 done latency"}, 32'(cyc), 32'd0);
    @(negedge clk);
    check({tag, " R13 done pulse"}, 32'(done), 32'd0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 req", 32'(req), 0);
    check("R1 done", 32'(done), 0);
    check("R1 busy/err/wb", {29'd0, busy, err, wb_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rdy_mode = 0;
    run_xfer("R6 push", 32'h7EFF_F150, 16'h40F0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    run_xfer("R3 pop", 32'h7EFF_F13C, 16'h020F, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    rdy_mode = 1;
    run_xfer("R4 up-before", 32'h0000_1000, 16'h8001, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    run_xfer("R5 down-after", 32'h0000_2000, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    run_xfer("R9 empty", 32'h0000_3000, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    run_xfer("R10 misaligned", 32'h0000_1002, 16'h00FF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    run_xfer("R12 busy start", 32'h0000_0800, 16'h0C30, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    rdy_mode = 2;
    run_xfer("R6 single", 32'h0000_0010, 16'h8000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    run_xfer("R5 wrap", 32'h0000_0004, 16'h0007, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    run_xfer("R11 R8 load", 32'h0000_0100, 16'hA5A5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: act hung exp finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule